// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer with Watchdog Reset

This block is a 16-bit down-counter behind a small 32-bit register bus, fed by a power-of-two clock prescaler. Software selects one of four behaviours for the shared counter:
- a free-running count that wraps;
- a periodic count that reloads itself;
- a one-shot count that stops after it fires;
- a watchdog count that must be refreshed before it runs out.

In the first three modes, an expiry raises a level interrupt. In watchdog mode, an expiry raises a one-cycle reset request and sets a sticky cause flag. The cause flag is cleared only by power-on reset, so software can still read it after the system reset it triggered.

Software programs a start value through the count register and then sets the enable bit in the control register. In watchdog mode it refreshes the count by writing the count register again. An expiry happens on a prescaler tick that finds the counter at zero. A start value N therefore expires (N+1)·2^(n+1) clock cycles after the prescaler restarts, where n is the prescaler code.

Top module: `modal_timer`

## Requirements
- R1: After power-on reset, all registers read 0, and `irq` and `wdt_rst_req` are low.
- R2: The register map is as follows.
  - Byte offset 0x00 holds the count. A read returns the current counter value in bits 15:0.
  - Offset 0x08 holds the control register. A read returns the last 8-bit value written, except that hardware clears the enable bit in R8.
  - Offset 0x0C holds the status register: bit 0 is the interrupt flag and bit 1 is the watchdog cause flag.
- R3: Control bits 3:0 hold the prescaler code n. The counter steps once every 2^(n+1) cycles, so code 0xF divides by 65536. The prescaler restarts on a count-register write or on a control write that sets the enable bit while it is clear.
- R4: A write to offset 0x00 sets both the counter and the stored reload value. The new value reads back in the next cycle.
- R5: Control bit 7 enables counting. While it is clear, the counter holds its value.
- R6: An expiry is a prescaler tick with the counter at 0. In free-running mode (bits 5:4 = 0), an expiry wraps the counter to 0xFFFF and sets the interrupt flag.
- R7: In periodic mode (bits 5:4 = 1), an expiry reloads the stored value and sets the interrupt flag.
- R8: In one-shot mode (bits 5:4 = 2), an expiry sets the interrupt flag, leaves the counter at 0 and clears control bit 7.
- R9: In watchdog mode (bits 5:4 = 3), an expiry does the following:
  - drives `wdt_rst_req` high for exactly one cycle;
  - sets the cause flag;
  - reloads the stored value;
  - leaves the interrupt flag unchanged.
- R10: A count-register write during watchdog counting restarts the full interval, and the old expiry never happens.
- R11: Clearing rules for the two flags:
  - The interrupt flag stays high until software writes 1 to status bit 0.
  - The cause flag stays high until software writes 1 to status bit 1, or until power-on reset.
  - `sys_rst_n` does not clear the cause flag.
  - Writing 0 to a status bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | System reset, active low, clears all but the cause flag |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high with `bus_sel` |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Level interrupt flag |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The reference edge is a count-register write or an enabling control write. After that edge the counter reads N − floor(j/D) at cycle j, with D = 2^(n+1). The expiry effects (interrupt, reset request, wrap or reload, cleared enable) appear at cycle j = (N+1)·D, and the reset request is gone again at the next cycle. The bench samples the combinational read port one time unit after each falling edge. It counts j from the returning write task, so every expectation lines up with the rising edge that produced it.

// File: rtl/mt_pkg.sv
package mt_pkg;
    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_ONESHOT  = 2'd2,
        MODE_WATCHDOG = 2'd3
    } mode_e;

    localparam int OFS_COUNT  = 'h0;
    localparam int OFS_CTRL   = 'h8;
    localparam int OFS_STATUS = 'hC;

    localparam int CTRL_W       = 8;
    localparam int CTRL_EN_BIT  = 7;
    localparam int CTRL_MODE_LO = 4;
    localparam int STAT_IRQ_BIT = 0;
    localparam int STAT_WDC_BIT = 1;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
    parameter int CODE_W = 4,
    localparam int DIV_W = 2 ** CODE_W,
    localparam int LIM_W = DIV_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    typedef struct packed {
        logic [DIV_W-1:0] pcnt;
    } pre_s;

    pre_s             st_d, st_q;
    logic [LIM_W-1:0] limit;

    always_comb begin
        limit = (LIM_W'(1) << (32'(code) + 32'd1)) - LIM_W'(1);
        tick  = en && (st_q.pcnt == limit[DIV_W-1:0]);
        st_d  = st_q;
        if (restart || !en || tick) st_d.pcnt = '0;
        else                        st_d.pcnt = st_q.pcnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the smallest division is 2, so ticks never come back to back
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/mt_counter.sv
module mt_counter
    import mt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  mode_e            mode,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] cnt;
    } ctr_s;

    ctr_s st_d, st_q;

    always_comb begin
        expire = tick && (st_q.cnt == '0);
        st_d   = st_q;
        if (load_wr) begin
            st_d.reload = load_val;
            st_d.cnt    = load_val;
        end else if (expire) begin
            unique case (mode)
                MODE_FREE:     st_d.cnt = '1;
                MODE_PERIODIC: st_d.cnt = st_q.reload;
                MODE_WATCHDOG: st_d.cnt = st_q.reload;
                default:       st_d.cnt = '0;
            endcase
        end else if (tick) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R4
    a_r4_load_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> cnt == $past(load_val));
    // R6
    a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_wr && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
    // R5
    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_wr) |=> $stable(cnt));
endmodule

// File: rtl/modal_timer.sv
module modal_timer
    import mt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wdt_rst_req
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              irq;
        logic              rst_req;
    } top_s;

    top_s       st_d, st_q;
    logic       cause_d, cause_q;
    logic       core_rst_n;
    logic       wr_count, wr_ctrl, wr_stat;
    logic       en, restart, tick, expire;
    mode_e      mode;
    logic [CNT_W-1:0] cnt;

    assign core_rst_n = por_n & sys_rst_n;
    assign wr_count = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_COUNT));
    assign wr_ctrl  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_stat  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_STATUS));
    assign en       = st_q.ctrl[CTRL_EN_BIT];
    assign mode     = mode_e'(st_q.ctrl[CTRL_MODE_LO +: 2]);
    assign restart  = wr_count || (wr_ctrl && bus_wdata[CTRL_EN_BIT] && !en);

    mt_prescaler #(.CODE_W(CODE_W)) u_pre (
        .clk     (clk),
        .rst_n   (core_rst_n),
        .en      (en),
        .restart (restart),
        .code    (st_q.ctrl[CODE_W-1:0]),
        .tick    (tick)
    );

    mt_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (core_rst_n),
        .tick     (tick),
        .mode     (mode),
        .load_wr  (wr_count),
        .load_val (bus_wdata[CNT_W-1:0]),
        .cnt      (cnt),
        .expire   (expire)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ctrl)
            st_d.ctrl = bus_wdata[CTRL_W-1:0];
        else if (expire && mode == MODE_ONESHOT)
            st_d.ctrl[CTRL_EN_BIT] = 1'b0;

        if (wr_stat && bus_wdata[STAT_IRQ_BIT]) st_d.irq = 1'b0;
        if (expire && mode != MODE_WATCHDOG)    st_d.irq = 1'b1;

        st_d.rst_req = expire && (mode == MODE_WATCHDOG);

        cause_d = cause_q;
        if (wr_stat && bus_wdata[STAT_WDC_BIT]) cause_d = 1'b0;
        if (expire && mode == MODE_WATCHDOG)    cause_d = 1'b1;
    end

    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) st_q <= '0;
        else             st_q <= st_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cause_q <= 1'b0;
        else        cause_q <= cause_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_COUNT))
            bus_rdata[CNT_W-1:0] = cnt;
        else if (bus_addr == ADDR_W'(OFS_CTRL))
            bus_rdata[CTRL_W-1:0] = st_q.ctrl;
        else if (bus_addr == ADDR_W'(OFS_STATUS)) begin
            bus_rdata[STAT_IRQ_BIT] = st_q.irq;
            bus_rdata[STAT_WDC_BIT] = cause_q;
        end
    end

    assign irq         = st_q.irq;
    assign wdt_rst_req = st_q.rst_req;

    // R9
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!core_rst_n)
        wdt_rst_req |=> !wdt_rst_req);
    // R9
    a_r9_cause_with_pulse: assert property (@(posedge clk) disable iff (!core_rst_n)
        wdt_rst_req |-> cause_q);
    // R9
    a_r9_no_irq_from_wd: assert property (@(posedge clk) disable iff (!core_rst_n)
        (expire && mode == MODE_WATCHDOG && !irq) |=> !irq);
    // R8
    a_r8_oneshot_stops: assert property (@(posedge clk) disable iff (!core_rst_n)
        (expire && mode == MODE_ONESHOT && !wr_ctrl) |=> !en);
    // R11
    a_r11_irq_level: assert property (@(posedge clk) disable iff (!core_rst_n)
        (irq && !(wr_stat && bus_wdata[STAT_IRQ_BIT])) |=> irq);
endmodule

// File: tb/modal_timer_test.sv
module modal_timer_test;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wdt_rst_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam int FREE = 0, PER = 1, ONE = 2, WD = 3;

    modal_timer uut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wdt_rst_req(wdt_rst_req)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<190000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int div_of(input int code);
        return 1 << (code + 1);
    endfunction

    function automatic int exp_cnt(input int n, input int d, input int j);
        return n - j / d;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic start(input int n, input int code, input int mode);
        wr(4'h0, 32'(n));
        wr(4'h8, 32'h80 | 32'(mode << 4) | 32'(code));
    endtask

    // follows the count from the last restart edge for up to stop cycles
    task automatic watch(input int n, input int d, input int mode, input int stop);
        logic [31:0] v, s, c;
        int due;
        due = (n + 1) * d;
        for (int j = 1; j <= stop; j++) begin
            @(negedge clk);
            rd(4'h0, v);
            if (j < due) begin
                // R3 R5 R6: step every d cycles, nothing fires early
                chk(v == 32'(exp_cnt(n, d, j)) && !irq && !wdt_rst_req,
                    "R3 count cadence", int'(v), exp_cnt(n, d, j));
            end else begin
                rd(4'hC, s);
                rd(4'h8, c);
                case (mode)
                    FREE: chk(v == 32'hFFFF && irq, "R6 free wrap", int'(v), 'hFFFF);
                    PER:  chk(v == 32'(n) && irq, "R7 periodic reload", int'(v), n);
                    ONE:  chk(v == 0 && irq && !c[7], "R8 one-shot stop", int'(c), 0);
                    default: chk(v == 32'(n) && !irq && wdt_rst_req && s[1],
                                 "R9 watchdog expiry", int'(s), 2);
                endcase
                @(negedge clk);
                if (mode == WD)
                    chk(!wdt_rst_req, "R9 pulse one cycle", int'(wdt_rst_req), 0);
                else
                    chk(irq, "R11 irq level held", int'(irq), 1);
                break;
            end
        end
    endtask

    task automatic cleanup();
        logic [31:0] s;
        wr(4'h8, 32'h0);
        wr(4'hC, 32'h3);
        rd(4'hC, s);
        chk(s == 0 && !irq, "R11 flags cleared by writing 1", int'(s), 0);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v); chk(v == 0, "R1 count after reset", int'(v), 0);
        rd(4'h8, v); chk(v == 0, "R1 control after reset", int'(v), 0);
        rd(4'hC, v); chk(v == 0 && !irq && !wdt_rst_req, "R1 status after reset", int'(v), 0);

        // R2 R4 readback while disabled
        wr(4'h0, 32'h0000_BEEF);
        rd(4'h0, v); chk(v == 32'hBEEF, "R4 load readback", int'(v), 'hBEEF);
        wr(4'h8, 32'h0000_002B);
        rd(4'h8, v); chk(v == 32'h2B, "R2 control readback", int'(v), 'h2B);
        repeat (10) @(negedge clk);
        rd(4'h0, v); chk(v == 32'hBEEF, "R5 disabled holds", int'(v), 'hBEEF);
        wr(4'h8, 32'h0);

        // directed: each mode
        start(3, 0, FREE); watch(3, 2, FREE, 100);  cleanup();
        start(2, 1, PER);  watch(2, 4, PER, 100);   cleanup();
        start(5, 0, ONE);  watch(5, 2, ONE, 100);   cleanup();
        start(0, 2, WD);   watch(0, 8, WD, 100);    cleanup();

        // R10 watchdog kick restarts the interval
        start(4, 1, WD);
        watch(4, 4, WD, 10);
        wr(4'h0, 32'd4);
        watch(4, 4, WD, 100);
        cleanup();

        // R5 clearing enable freezes the count
        start(10, 0, PER);
        watch(10, 2, PER, 6);
        wr(4'h8, 32'h10);
        repeat (20) @(negedge clk);
        rd(4'h0, v);
        chk(v == 32'(exp_cnt(10, 2, 7)), "R5 stop holds count", int'(v), exp_cnt(10, 2, 7));
        cleanup();

        // R11 cause survives system reset, write 0 ignored, POR clears
        start(1, 0, WD); watch(1, 2, WD, 100);
        wr(4'h0, 32'd3);
        wr(4'hC, 32'h1);
        sys_rst_n = 1'b0;
        @(negedge clk);
        sys_rst_n = 1'b1;
        @(negedge clk);
        rd(4'hC, v); chk(v == 32'h2, "R11 cause kept over system reset", int'(v), 2);
        rd(4'h8, v); chk(v == 0, "R11 control cleared by system reset", int'(v), 0);
        wr(4'hC, 32'h0);
        rd(4'hC, v); chk(v == 32'h2, "R11 writing 0 ignored", int'(v), 2);
        wr(4'hC, 32'h2);
        rd(4'hC, v); chk(v == 0, "R11 cause cleared by write 1", int'(v), 0);
        start(0, 0, WD); watch(0, 2, WD, 100);
        wr(4'h8, 32'h0);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        rd(4'hC, v); chk(v == 0, "R1 power-on reset clears cause", int'(v), 0);

        // R3 random trials
        for (int t = 0; t < 14; t++) begin
            int n, code, mode;
            n    = int'($urandom_range(0, 12));
            code = int'($urandom_range(0, 3));
            mode = int'($urandom_range(0, 3));
            start(n, code, mode);
            watch(n, div_of(code), mode, 100000);
            cleanup();
        end

        // R3 largest prescaler code divides by 65536
        start(0, 15, FREE);
        watch(0, 65536, FREE, 70000);
        cleanup();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule